// File: doc/BRIEF.md
# Timer Channel Interrupt Request Controller

This block generates interrupt requests for a single timer channel. The counter sits outside the block and sends two one-cycle event pulses: one when the count meets its target and one when it wraps past its maximum. The block combines those pulses with four mode-control bits:

- a target-interrupt enable;
- an overflow-interrupt enable;
- a repeat/one-shot select;
- a toggle/pulse select.

From these it keeps an internal request-enable line and two sticky event flags. When an interrupt fires, the block sets this channel's bit in a sticky status word. Software clears that bit by writing a 1 to it. The bit position is fixed by a channel-index parameter, so several channels can be OR-merged into one shared status register.

The request line is a small state machine with three states:

- ARMED: the line is high.
- RECOVER: the line is low, and a fixed timer is counting back to high.
- PARKED: the line is low and waits for an event or a mode write.

The transitions are:

- ARMED to RECOVER: "pulse-drop", taken on an enabled event in repeat-pulse mode.
- ARMED to PARKED: "toggle-drop", taken on an enabled event in toggle mode.
- RECOVER to ARMED: "recover-done", taken when the low-time counter expires.
- PARKED to ARMED: "toggle-rise", taken on an enabled event in repeat-toggle mode.
- Any state to ARMED: "rearm", taken on an accepted mode write.

All other combinations hold the current state.

A mode write always updates both event enables. It clears the flags and re-latches repeat/toggle only if no flag is pending with an enable on. If one is, the old interrupt mode is kept.

Top module: `tmr_irq_ctrl`

## Requirements
- R1: The mode input carries four bits: bit 4 enables target interrupts, bit 5 enables overflow interrupts, bit 6 selects repeat (0 means one-shot), and bit 7 selects toggle (0 means pulse). An event whose enable bit is 0 never fires, but it still sets its own flag.
- R2: After reset the request line is high, both flags are 0 and the status word is 0.
- R3: An enabled event fires only when the request line is high and either repeat is latched or that event's flag was 0 before the event.
- R4: On an enabled event with the line high, the line responds according to the latched mode:
  - repeat-pulse: the line goes low.
  - toggle (repeat or one-shot): the line inverts.
  - one-shot pulse: the line is unchanged.

  With the line low, only repeat-toggle changes it, by inverting it back high without firing.
- R5: In repeat-pulse mode the line stays low for exactly LOW_CYC cycles (default 2) and then returns high. Events during the low time neither fire nor restart the timer.
- R6: A mode write is accepted only if it is not the case that (target flag or overflow flag is set) and (target or overflow enable is on), using the enables held before the write. An accepted write clears both flags, forces the line high and latches the new repeat and toggle bits. A rejected write keeps the flags and the old repeat/toggle setting.
- R7: When an accepted mode write and an event occur in the same cycle, the write wins: the event neither fires nor sets a flag.
- R8: A firing sets status bit 4+CHAN_IDX (mask 0x10 for channel 0). The bit stays set until a clear write with a 1 in that bit position. A firing in the same cycle as such a clear leaves the bit set.
- R9: A target event and an overflow event in the same cycle form one firing: both flags are set and the line changes once.
- R10: Each flag stays set until an accepted mode write clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tgt_evt | input | 1 | One-cycle pulse: counter reached its target |
| ovf_evt | input | 1 | One-cycle pulse: counter wrapped past its maximum |
| mode_wr | input | 1 | Mode-register write strobe |
| mode_data | input | 4 | Mode bits 7:4 (toggle, repeat, overflow enable, target enable) |
| clr_wr | input | 1 | Status clear strobe |
| clr_data | input | STAT_W | Write-1-to-clear mask for the status word |
| irq_status | output | STAT_W | Sticky status word with this channel's bit |
| req_line | output | 1 | Internal request-enable line |
| tgt_flag | output | 1 | Sticky target-reached flag |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The bench drives each event against a blocked mode write. A design that compares each flag only with its own enable, rather than any flag with any enable, would wrongly accept that write and then refire in one-shot mode.

It also lands events inside the repeat-pulse low window. A design that restarts the low timer would hold the line low for a third cycle, and one that ignores the line state would set the status bit again.

Same-cycle collisions are exercised next:

- target with overflow: a design that handles them as two firings would end with the line in the wrong state.
- mode write with event: a design that lets the event through would leave a flag set after the write.
- firing with status clear: a design that lets the clear win would lose a request.

Finally, toggle mode is run in both the repeat and the one-shot variants. This exposes a line that never rises again in repeat mode, or one that rises again in one-shot mode.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;

    // Bit positions inside the mode word (the port carries bits 7:4)
    localparam int unsigned MB_TGT_EN = 4;
    localparam int unsigned MB_OVF_EN = 5;
    localparam int unsigned MB_REPEAT = 6;
    localparam int unsigned MB_TOGGLE = 7;

    // Channel 0 owns status bit STAT_BASE_BIT, channel n owns bit base+n
    localparam int unsigned STAT_BASE_BIT = 4;

    typedef enum logic [1:0] {
        LN_ARMED   = 2'd0,   // line high
        LN_RECOVER = 2'd1,   // line low, timed return
        LN_PARKED  = 2'd2    // line low, waits for event or mode write
    } line_state_e;

endpackage

// File: rtl/tmr_irq_mode.sv
module tmr_irq_mode
    import tmr_irq_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       mode_wr,
    input  logic [MB_TOGGLE:MB_TGT_EN] mode_data,
    input  logic                       tgt_evt,
    input  logic                       ovf_evt,
    output logic                       accept,
    output logic                       tgt_en,
    output logic                       ovf_en,
    output logic                       rpt,
    output logic                       tgl,
    output logic                       tgt_flag,
    output logic                       ovf_flag
);

    logic pend_block;

    // A write is refused while any flag is pending with any enable on
    assign pend_block = (tgt_flag | ovf_flag) & (tgt_en | ovf_en);
    assign accept     = mode_wr & ~pend_block;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_en   <= 1'b0;
            ovf_en   <= 1'b0;
            rpt      <= 1'b0;
            tgl      <= 1'b0;
            tgt_flag <= 1'b0;
            ovf_flag <= 1'b0;
        end else begin
            if (mode_wr) begin
                tgt_en <= mode_data[MB_TGT_EN];
                ovf_en <= mode_data[MB_OVF_EN];
            end
            if (accept) begin
                rpt      <= mode_data[MB_REPEAT];
                tgl      <= mode_data[MB_TOGGLE];
                tgt_flag <= 1'b0;
                ovf_flag <= 1'b0;
            end else begin
                tgt_flag <= tgt_flag | tgt_evt;
                ovf_flag <= ovf_flag | ovf_evt;
            end
        end
    end

endmodule

// File: rtl/tmr_irq_line.sv
module tmr_irq_line
    import tmr_irq_pkg::*;
#(
    parameter int unsigned LOW_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic act_tgt,
    input  logic act_ovf,
    input  logic tgt_flag,
    input  logic ovf_flag,
    input  logic rpt,
    input  logic tgl,
    output logic req_line,
    output logic fire
);

    localparam int unsigned CNT_W = $clog2(LOW_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LOW_CYC - 1);

    line_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             act, elig;

    assign act  = act_tgt | act_ovf;
    assign elig = (act_tgt & (rpt | ~tgt_flag)) | (act_ovf & (rpt | ~ovf_flag));

    // State register and low-time counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LN_ARMED;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q != LN_RECOVER)
                cnt_q <= '0;
            else
                cnt_q <= cnt_q + 1'b1;
        end
    end

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LN_ARMED: begin
                if (!accept && act) begin
                    if (tgl)
                        state_d = LN_PARKED;      // toggle-drop
                    else if (rpt)
                        state_d = LN_RECOVER;     // pulse-drop
                end
            end
            LN_RECOVER: begin
                if (accept)
                    state_d = LN_ARMED;           // rearm
                else if (cnt_q == CNT_LAST)
                    state_d = LN_ARMED;           // recover-done
            end
            LN_PARKED: begin
                if (accept)
                    state_d = LN_ARMED;           // rearm
                else if (act && rpt && tgl)
                    state_d = LN_ARMED;           // toggle-rise
            end
            default: state_d = LN_ARMED;
        endcase
    end

    // Outputs
    always_comb begin
        req_line = (state_q == LN_ARMED);
        fire     = (state_q == LN_ARMED) & ~accept & elig;
    end

endmodule

// File: rtl/tmr_irq_status.sv
module tmr_irq_status
    import tmr_irq_pkg::*;
#(
    parameter int unsigned STAT_W   = 32,
    parameter int unsigned CHAN_IDX = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic              clr_wr,
    input  logic [STAT_W-1:0] clr_data,
    output logic [STAT_W-1:0] stat_q
);

    localparam int unsigned     BIT_POS = STAT_BASE_BIT + CHAN_IDX;
    localparam logic [STAT_W-1:0] CH_MASK = STAT_W'(1) << BIT_POS;

    logic [STAT_W-1:0] clr_mask, set_mask;

    assign clr_mask = clr_wr ? clr_data : '0;
    assign set_mask = fire ? CH_MASK : '0;

    // Set takes priority over a simultaneous clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            stat_q <= '0;
        else
            stat_q <= (stat_q & ~clr_mask) | set_mask;
    end

endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl
    import tmr_irq_pkg::*;
#(
    parameter int unsigned STAT_W   = 32,
    parameter int unsigned CHAN_IDX = 0,
    parameter int unsigned LOW_CYC  = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tgt_evt,
    input  logic                       ovf_evt,
    input  logic                       mode_wr,
    input  logic [MB_TOGGLE:MB_TGT_EN] mode_data,
    input  logic                       clr_wr,
    input  logic [STAT_W-1:0]          clr_data,
    output logic [STAT_W-1:0]          irq_status,
    output logic                       req_line,
    output logic                       tgt_flag,
    output logic                       ovf_flag
);

    logic accept, tgt_en, ovf_en, rpt, tgl, fire;
    logic act_tgt, act_ovf;

    tmr_irq_mode u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_wr   (mode_wr),
        .mode_data (mode_data),
        .tgt_evt   (tgt_evt),
        .ovf_evt   (ovf_evt),
        .accept    (accept),
        .tgt_en    (tgt_en),
        .ovf_en    (ovf_en),
        .rpt       (rpt),
        .tgl       (tgl),
        .tgt_flag  (tgt_flag),
        .ovf_flag  (ovf_flag)
    );

    assign act_tgt = tgt_evt & tgt_en;
    assign act_ovf = ovf_evt & ovf_en;

    tmr_irq_line #(.LOW_CYC(LOW_CYC)) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .act_tgt  (act_tgt),
        .act_ovf  (act_ovf),
        .tgt_flag (tgt_flag),
        .ovf_flag (ovf_flag),
        .rpt      (rpt),
        .tgl      (tgl),
        .req_line (req_line),
        .fire     (fire)
    );

    tmr_irq_status #(.STAT_W(STAT_W), .CHAN_IDX(CHAN_IDX)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (fire),
        .clr_wr   (clr_wr),
        .clr_data (clr_data),
        .stat_q   (irq_status)
    );

endmodule

// File: rtl/tmr_irq_ctrl_chk.sv
module tmr_irq_ctrl_chk
    import tmr_irq_pkg::*;
#(
    parameter int unsigned STAT_W   = 32,
    parameter int unsigned CHAN_IDX = 0,
    parameter int unsigned LOW_CYC  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tgt_evt,
    input logic              ovf_evt,
    input logic              mode_wr,
    input logic [STAT_W-1:0] irq_status,
    input logic              req_line,
    input logic              tgt_flag,
    input logic              ovf_flag,
    input logic              tgt_en,
    input logic              ovf_en,
    input logic              rpt,
    input logic              tgl
);

    localparam logic [STAT_W-1:0] CH_MASK = STAT_W'(1) << (STAT_BASE_BIT + CHAN_IDX);
    localparam int unsigned RUN_W = $clog2(LOW_CYC + 2);

    logic [RUN_W-1:0] low_run;
    logic             any_act;

    assign any_act = (tgt_evt & tgt_en) | (ovf_evt & ovf_en);

    always_ff @(posedge clk) begin
        if (!rst_n)
            low_run <= '0;
        else if (req_line)
            low_run <= '0;
        else if (low_run != RUN_W'(LOW_CYC))
            low_run <= low_run + 1'b1;
    end

    // R3
    fire_needs_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((irq_status & CH_MASK) != '0) && (($past(irq_status) & CH_MASK) == '0)) |-> $past(req_line));

    // R6
    mode_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && !((tgt_flag || ovf_flag) && (tgt_en || ovf_en))) |=> (req_line && !tgt_flag && !ovf_flag));

    // R10
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((tgt_flag && !mode_wr) |=> tgt_flag) and ((ovf_flag && !mode_wr) |=> ovf_flag));

    // R4
    toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (any_act && rpt && tgl && !mode_wr) |=> (req_line != $past(req_line)));

    // R5
    recover_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt && !tgl && !req_line) |-> (low_run < RUN_W'(LOW_CYC)));

endmodule

bind tmr_irq_ctrl tmr_irq_ctrl_chk #(
    .STAT_W   (STAT_W),
    .CHAN_IDX (CHAN_IDX),
    .LOW_CYC  (LOW_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tgt_evt    (tgt_evt),
    .ovf_evt    (ovf_evt),
    .mode_wr    (mode_wr),
    .irq_status (irq_status),
    .req_line   (req_line),
    .tgt_flag   (tgt_flag),
    .ovf_flag   (ovf_flag),
    .tgt_en     (tgt_en),
    .ovf_en     (ovf_en),
    .rpt        (rpt),
    .tgl        (tgl)
);

// File: tb/tmr_irq_ctrl_tb.sv
`timescale 1ns/1ps
module tmr_irq_ctrl_tb;

    localparam int unsigned STAT_W = 32;
    localparam logic [31:0] CH0 = 32'h10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tgt_evt = 1'b0, ovf_evt = 1'b0, mode_wr = 1'b0, clr_wr = 1'b0;
    logic [7:4]        mode_data = '0;
    logic [STAT_W-1:0] clr_data = '0;
    logic [STAT_W-1:0] irq_status;
    logic              req_line, tgt_flag, ovf_flag;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    tmr_irq_ctrl #(.STAT_W(STAT_W), .CHAN_IDX(0), .LOW_CYC(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .tgt_evt(tgt_evt), .ovf_evt(ovf_evt),
        .mode_wr(mode_wr), .mode_data(mode_data), .clr_wr(clr_wr), .clr_data(clr_data),
        .irq_status(irq_status), .req_line(req_line), .tgt_flag(tgt_flag), .ovf_flag(ovf_flag)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // Drive one cycle of stimulus from a falling edge, sample at the next one
    task automatic apply(input logic t, input logic o, input logic mw, input logic [3:0] md,
                         input logic cw, input logic [31:0] cd);
        tgt_evt = t; ovf_evt = o; mode_wr = mw; mode_data = md; clr_wr = cw; clr_data = cd;
        @(negedge clk);
        tgt_evt = 0; ovf_evt = 0; mode_wr = 0; mode_data = '0; clr_wr = 0; clr_data = '0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    // Zero the enables first so that the following write is always accepted
    task automatic set_mode(input logic [3:0] md);
        apply(0, 0, 1, 4'b0000, 0, 0);
        apply(0, 0, 1, md, 0, 0);
    endtask

    task automatic t_reset();
        chk("R2 line", {31'd0, req_line}, 1);
        chk("R2 flags", {30'd0, tgt_flag, ovf_flag}, 0);
        chk("R2 status", irq_status, 0);
    endtask

    task automatic t_oneshot();
        set_mode(4'b0001);                    // target enable only, one-shot pulse
        apply(1, 0, 0, 0, 0, 0);
        chk("R3 first fire", irq_status, CH0);
        chk("R10 tflag", {31'd0, tgt_flag}, 1);
        chk("R4 one-shot pulse line", {31'd0, req_line}, 1);
        apply(0, 0, 0, 0, 1, CH0);
        chk("R8 w1c", irq_status, 0);
        apply(1, 0, 0, 0, 0, 0);
        chk("R3 one-shot suppress", irq_status, 0);
        apply(0, 1, 0, 0, 0, 0);
        chk("R1 disabled ovf flag", {31'd0, ovf_flag}, 1);
        chk("R1 disabled ovf no fire", irq_status, 0);
    endtask

    task automatic t_blocked();
        apply(0, 0, 1, 4'b0101, 0, 0);        // refused: flag pending with enable on
        chk("R6 rejected keeps flags", {30'd0, tgt_flag, ovf_flag}, 2'b11);
        apply(1, 0, 0, 0, 0, 0);
        chk("R6 old one-shot kept", irq_status, 0);
    endtask

    task automatic t_rep_pulse();
        set_mode(4'b0101);
        chk("R6 accepted clears", {30'd0, tgt_flag, ovf_flag}, 0);
        apply(1, 0, 0, 0, 0, 0);
        chk("R3 repeat fire", irq_status, CH0);
        chk("R5 low 1", {31'd0, req_line}, 0);
        idle();
        chk("R5 low 2", {31'd0, req_line}, 0);
        idle();
        chk("R5 back high", {31'd0, req_line}, 1);
        apply(0, 0, 0, 0, 1, CH0);
        apply(1, 0, 0, 0, 0, 0);
        chk("R3 repeat refire with flag", irq_status, CH0);
        apply(1, 0, 0, 0, 1, CH0);            // event inside low window
        chk("R5 no fire while low", irq_status, 0);
        chk("R5 still low", {31'd0, req_line}, 0);
        idle();
        chk("R5 no restart", {31'd0, req_line}, 1);
    endtask

    task automatic t_rep_toggle();
        set_mode(4'b1101);
        apply(0, 0, 0, 0, 1, CH0);
        apply(1, 0, 0, 0, 0, 0);
        chk("R4 toggle fire", irq_status, CH0);
        chk("R4 toggle low", {31'd0, req_line}, 0);
        apply(0, 0, 0, 0, 1, CH0);
        chk("R4 parked", {31'd0, req_line}, 0);
        apply(1, 0, 0, 0, 0, 0);
        chk("R4 toggle rise no fire", irq_status, 0);
        chk("R4 toggle rise", {31'd0, req_line}, 1);
        apply(1, 0, 0, 0, 0, 0);
        chk("R4 toggle refire", irq_status, CH0);
    endtask

    task automatic t_os_toggle();
        set_mode(4'b1001);
        apply(0, 0, 0, 0, 1, CH0);
        apply(1, 0, 0, 0, 0, 0);
        chk("R4 one-shot toggle low", {31'd0, req_line}, 0);
        apply(0, 0, 0, 0, 1, CH0);
        apply(1, 0, 0, 0, 0, 0);
        chk("R4 one-shot toggle stays low", {31'd0, req_line}, 0);
        chk("R4 one-shot toggle no fire", irq_status, 0);
    endtask

    task automatic t_both();
        set_mode(4'b0111);
        apply(0, 0, 0, 0, 1, 32'hFFFF_FFFF);
        apply(1, 1, 0, 0, 0, 0);
        chk("R9 single fire", irq_status, CH0);
        chk("R9 both flags", {30'd0, tgt_flag, ovf_flag}, 2'b11);
        idle();
        chk("R9 low once", {31'd0, req_line}, 0);
        idle();
        chk("R9 recovered", {31'd0, req_line}, 1);
    endtask

    task automatic t_write_wins();
        apply(0, 0, 0, 0, 1, CH0);
        apply(0, 0, 1, 4'b0000, 0, 0);
        apply(1, 0, 1, 4'b0111, 0, 0);
        chk("R7 write wins flag", {31'd0, tgt_flag}, 0);
        chk("R7 write wins status", irq_status, 0);
        chk("R7 line high", {31'd0, req_line}, 1);
    endtask

    task automatic t_set_wins();
        apply(1, 0, 0, 0, 1, CH0);
        chk("R8 set beats clear", irq_status, CH0);
        idle(); idle();
        apply(0, 0, 0, 0, 1, 32'h0);
        chk("R8 zero mask keeps", irq_status, CH0);
        apply(0, 0, 0, 0, 1, 32'hFFFF_FFFF);
        chk("R8 clear all", irq_status, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_oneshot();
        t_blocked();
        t_rep_pulse();
        t_rep_toggle();
        t_os_toggle();
        t_both();
        t_write_wins();
        t_set_wins();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule